// File: doc/BRIEF.md
# Indirect CSR access engine

This engine carries out byte-granular reads and writes into a slave device's control/status register space, which is reached only through two registers: a 32-bit data register and a command register. A request names a starting CSR address, a byte count and a direction. The bytes come from, or go to, a local byte buffer that the engine indexes from offset zero. The engine cuts the request into chunks whose size is legal for the address alignment. For each chunk it writes a command word and then reads the command register back until the slave reports that the operation is no longer busy. The payload moves through the data register: the engine writes it before the command on a write, and reads it after completion on a read.

All register traffic leaves the block on a simple 32-bit request/acknowledge port. The serial link that carries it and the contents of the slave's registers belong to other blocks. A poll limit ends a chunk that never completes and reports the failure.

Top module: `csr_indirect_engine`

## Requirements
- R1: A register access is presented on `reg_req` and held, with address and direction unchanged, until the cycle in which `reg_ack` is high. Each acknowledge completes exactly one access.
- R2: The data register sits at 0x0300 and the command register at 0x0304. A command word sets bit 31 and sets bit 30 only for a read. It carries the chunk size in bits 18:16 and the CSR address in bits 15:0, and all other bits are zero.
- R3: Let t be the smaller of 4 and the bytes left. The chunk size is 1 at an odd address. At an address whose two low bits are 10 it is 2 when t is even and 1 when t is odd. At other addresses it is t, except that t = 3 gives 1. No chunk is 0 or 3 bytes, and no chunk crosses its own natural alignment.
- R4: After every command word, the engine reads the command register until a read returns bit 31 clear. It issues exactly one poll for each busy response, plus the final clear one.
- R5: A write chunk loads the data register before it writes its command. A read chunk writes its command, polls, and reads the data register only after a poll has returned bit 31 clear.
- R6: After each chunk, the CSR address and the buffer offset both advance by the chunk size and the remaining count falls by it. Every requested byte is transferred exactly once, and no byte outside the request is touched.
- R7: On a write, buffer bytes go into the data word least significant byte first, starting at bit 0. Data word bytes above the chunk size are zero.
- R8: On a read, the low chunk-size bytes of the data word go to the buffer at the current offset, least significant byte first. The upper bytes of the data word are discarded, and buffer bytes beyond the request keep their values.
- R9: `busy` rises the cycle after a request is accepted and stays high until the request ends. On success, `done` is high for one cycle, in the cycle in which `busy` has just fallen. A zero-length request ends this way with no register traffic.
- R10: If POLL_LIMIT consecutive polls of one chunk all return busy, the request ends with a one-cycle `err` and no `done`. A chunk whose busy clears on poll number POLL_LIMIT completes normally.
- R11: `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (accepted when idle) |
| req_write | input | 1 | 1 = buffer to CSR, 0 = CSR to buffer |
| req_addr | input | 16 | First CSR byte address (below 0x1000) |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle poll-timeout pulse |
| reg_req | output | 1 | Register access pending |
| reg_we | output | 1 | 1 = register write |
| reg_addr | output | 16 | Register address (0x0300 or 0x0304) |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Access complete, read data valid |
| reg_rdata | input | 32 | Register read data |
| buf_rptr | output | LEN_W | Buffer offset of the current write chunk |
| buf_rword | input | 32 | Buffer bytes at buf_rptr..+3, LSB first |
| buf_we | output | 1 | Buffer store strobe |
| buf_wptr | output | LEN_W | Buffer offset of the store |
| buf_wdata | output | 32 | Store bytes, LSB first |
| buf_wsize | output | 3 | Number of valid store bytes |

## Verification
Two events can fall on the same cycle: the poll that ends a chunk, and the expiry of the poll timer. When the slave model answers busy exactly POLL_LIMIT-1 times, the clearing response arrives on the very poll at which the timer would otherwise expire. The bench requires `done`, no `err`, and POLL_LIMIT polls in that case. One more busy answer must turn the same request into an `err` with no `done`. A second collision is a new `req_valid` that arrives while `busy` is high. It is provoked mid-request, and it is judged by the absence of any command word that does not belong to the running request and by a single `done`.

// File: rtl/csr_eng_pkg.sv
package csr_eng_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CALC,
    S_LOAD,
    S_CMD,
    S_POLL,
    S_FETCH
  } eng_state_e;

  localparam logic [15:0] DATA_REG_ADDR = 16'h0300;
  localparam logic [15:0] CMD_REG_ADDR  = 16'h0304;
  localparam int          CMD_BUSY_BIT  = 31;
  localparam int          CMD_READ_BIT  = 30;
  localparam int          CMD_SIZE_LSB  = 16;

  // Legal chunk size from the two low address bits and the tentative size (1..4).
  function automatic logic [2:0] legal_chunk(input logic [1:0] alo, input logic [2:0] tent);
    logic [2:0] s;
    if (alo[0])
      s = 3'd1;
    else if (alo[1])
      s = tent[0] ? 3'd1 : 3'd2;
    else if (tent == 3'd3)
      s = 3'd1;
    else
      s = tent;
    return s;
  endfunction

  function automatic logic [31:0] cmd_word(input logic rd, input logic [2:0] sz,
                                           input logic [15:0] a);
    logic [31:0] w;
    w = '0;
    w[CMD_BUSY_BIT] = 1'b1;
    w[CMD_READ_BIT] = rd;
    w[CMD_SIZE_LSB +: 3] = sz;
    w[15:0] = a;
    return w;
  endfunction

  // Keep the low sz bytes of a word, clear the rest.
  function automatic logic [31:0] low_bytes(input logic [31:0] w, input logic [2:0] sz);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < sz) r[8*k +: 8] = w[8*k +: 8];
    return r;
  endfunction

endpackage

// File: rtl/csr_chunk_sizer.sv
module csr_chunk_sizer
  import csr_eng_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [1:0]       addr_lo,
  input  logic [LEN_W-1:0] remaining,
  output logic [2:0]       size
);
  localparam logic [LEN_W-1:0] THREE = LEN_W'(3);

  logic [2:0] tentative;

  always_comb begin
    tentative = (remaining > THREE) ? 3'd4 : remaining[2:0];
    size      = legal_chunk(addr_lo, tentative);
  end
endmodule

// File: rtl/csr_poll_timer.sv
module csr_poll_timer #(
  parameter int POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear || expire)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end

  AST_POLL_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R10
  AST_POLL_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clear && !expire |=> cnt_q == $past(cnt_q) + 1'b1); // R10
endmodule

// File: rtl/csr_indirect_engine.sv
module csr_indirect_engine
  import csr_eng_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             reg_req,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata,
  output logic [LEN_W-1:0] buf_rptr,
  input  logic [31:0]      buf_rword,
  output logic             buf_we,
  output logic [LEN_W-1:0] buf_wptr,
  output logic [31:0]      buf_wdata,
  output logic [2:0]       buf_wsize
);
  localparam logic [LEN_W-1:0] LEN_ZERO = '0;

  eng_state_e       state_q;
  logic             write_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] ptr_q;
  logic [2:0]       size_q;
  logic             done_q, err_q;
  logic             bwe_q;
  logic [LEN_W-1:0] bwptr_q;
  logic [31:0]      bwdata_q;
  logic [2:0]       bwsize_q;
  logic             data_loaded_q;
  logic             clear_seen_q;

  // Named internal events
  logic [2:0]       next_size;
  logic             poll_ack;
  logic             busy_seen;
  logic             clear_seen;
  logic             cmd_ack;
  logic             fetch_ack;
  logic             chunk_end;
  logic             timeout_evt;
  logic             all_sent;
  logic             fin_evt;
  logic [LEN_W-1:0] size_ext;

  csr_chunk_sizer #(.LEN_W(LEN_W)) u_sizer (
    .addr_lo   (addr_q[1:0]),
    .remaining (rem_q),
    .size      (next_size)
  );

  csr_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cmd_ack),
    .tick   (busy_seen),
    .expire (timeout_evt)
  );

  assign size_ext   = LEN_W'(size_q);
  assign poll_ack   = (state_q == S_POLL) && reg_ack;
  assign busy_seen  = poll_ack && reg_rdata[CMD_BUSY_BIT];
  assign clear_seen = poll_ack && !reg_rdata[CMD_BUSY_BIT];
  assign cmd_ack    = (state_q == S_CMD) && reg_ack;
  assign fetch_ack  = (state_q == S_FETCH) && reg_ack;
  assign chunk_end  = (clear_seen && write_q) || fetch_ack;
  assign all_sent   = (state_q == S_CALC) && (rem_q == LEN_ZERO);
  assign fin_evt    = all_sent || timeout_evt;

  // Register port
  always_comb begin
    reg_req   = (state_q == S_LOAD) || (state_q == S_CMD) ||
                (state_q == S_POLL) || (state_q == S_FETCH);
    reg_we    = (state_q == S_LOAD) || (state_q == S_CMD);
    reg_addr  = ((state_q == S_LOAD) || (state_q == S_FETCH)) ? DATA_REG_ADDR : CMD_REG_ADDR;
    reg_wdata = '0;
    if (state_q == S_LOAD)
      reg_wdata = low_bytes(buf_rword, size_q);
    else if (state_q == S_CMD)
      reg_wdata = cmd_word(!write_q, size_q, addr_q);
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign buf_rptr  = ptr_q;
  assign buf_we    = bwe_q;
  assign buf_wptr  = bwptr_q;
  assign buf_wdata = bwdata_q;
  assign buf_wsize = bwsize_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      write_q       <= 1'b0;
      addr_q        <= '0;
      rem_q         <= '0;
      ptr_q         <= '0;
      size_q        <= '0;
      done_q        <= 1'b0;
      err_q         <= 1'b0;
      bwe_q         <= 1'b0;
      bwptr_q       <= '0;
      bwdata_q      <= '0;
      bwsize_q      <= '0;
      data_loaded_q <= 1'b0;
      clear_seen_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bwe_q  <= 1'b0;

      if (fetch_ack) begin
        bwe_q    <= 1'b1;
        bwptr_q  <= ptr_q;
        bwdata_q <= low_bytes(reg_rdata, size_q);
        bwsize_q <= size_q;
      end

      if (chunk_end) begin
        addr_q <= addr_q + 16'(size_q);
        ptr_q  <= ptr_q + size_ext;
        rem_q  <= rem_q - size_ext;
      end

      unique case (state_q)
        S_IDLE: if (req_valid) begin
          write_q <= req_write;
          addr_q  <= req_addr;
          rem_q   <= req_len;
          ptr_q   <= '0;
          state_q <= S_CALC;
        end
        S_CALC: begin
          if (all_sent) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            size_q  <= next_size;
            state_q <= write_q ? S_LOAD : S_CMD;
          end
        end
        S_LOAD: if (reg_ack) begin
          data_loaded_q <= 1'b1;
          state_q       <= S_CMD;
        end
        S_CMD: if (reg_ack) begin
          data_loaded_q <= 1'b0;
          clear_seen_q  <= 1'b0;
          state_q       <= S_POLL;
        end
        S_POLL: begin
          if (timeout_evt) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (clear_seen) begin
            clear_seen_q <= 1'b1;
            state_q      <= write_q ? S_CALC : S_FETCH;
          end
        end
        S_FETCH: if (reg_ack) state_q <= S_CALC;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we)); // R1
  AST_CHUNK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_CMD |-> ((addr_q[2:0] & (size_q - 3'd1)) == 3'd0) &&
                         size_q != 3'd0 && size_q != 3'd3 && size_ext <= rem_q); // R3
  AST_CMD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_CMD && write_q |-> data_loaded_q); // R5
  AST_FETCH_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_FETCH |-> clear_seen_q); // R5
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_end |=> rem_q == $past(rem_q) - LEN_W'($past(size_q))); // R6
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin_evt |=> busy); // R9
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !fin_evt |=> $stable(write_q)); // R11
endmodule

// File: tb/tb_csr_indirect_engine.sv
module tb_csr_indirect_engine;
  localparam int LEN_W = 8;
  localparam int LIMIT = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [15:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             busy, done, err;
  logic             reg_req, reg_we;
  logic [15:0]      reg_addr;
  logic [31:0]      reg_wdata;
  logic             reg_ack = 1'b0;
  logic [31:0]      reg_rdata = '0;
  logic [LEN_W-1:0] buf_rptr, buf_wptr;
  logic [31:0]      buf_rword;
  logic             buf_we;
  logic [31:0]      buf_wdata;
  logic [2:0]       buf_wsize;

  always #2 clk = ~clk;

  csr_indirect_engine #(.LEN_W(LEN_W), .POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .buf_rptr(buf_rptr), .buf_rword(buf_rword),
    .buf_we(buf_we), .buf_wptr(buf_wptr), .buf_wdata(buf_wdata), .buf_wsize(buf_wsize)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem [0:4095];
  logic [7:0] lbuf [0:15];

  // slave and expectation state
  int    e_addr, e_rem, e_off, chunks, polls, xfers, pend, pcfg, lat_cfg, lat_cnt;
  bit    e_rd, loaded, polled_clear, active;
  int    done_cnt, err_cnt, gaps;
  logic [31:0] dreg, lastcmd;
  logic [15:0] hold_a;
  logic        hold_we;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_size(input int a, input int r);
    int t;
    t = (r < 4) ? r : 4;
    if (a % 2 == 1) return 1;
    if (a % 4 == 2) return (t % 2 == 0) ? 2 : 1;
    if (t == 3) return 1;
    return t;
  endfunction

  always_comb begin
    buf_rword = '0;
    for (int k = 0; k < 4; k++)
      if (int'(buf_rptr) + k < 16) buf_rword[8*k +: 8] = lbuf[int'(buf_rptr) + k];
  end

  task automatic service();
    int sz;
    logic [31:0] expw, packed_w;
    xfers++;
    if (reg_we && reg_addr == 16'h0300) begin
      dreg   = reg_wdata;
      loaded = 1'b1;
    end else if (reg_we && reg_addr == 16'h0304) begin
      sz   = exp_size(e_addr, e_rem);
      expw = 32'h8000_0000 | (e_rd ? 32'h4000_0000 : 32'h0) | (32'(sz) << 16) | 32'(e_addr);
      chk(reg_wdata == expw, "R2 R3 command word", reg_wdata, expw);
      if (!e_rd) begin
        chk(loaded, "R5 data before command", 0, 1);
        packed_w = 0;
        for (int k = 0; k < sz; k++) packed_w = packed_w | (32'(lbuf[e_off + k]) << (8 * k));
        chk(dreg == packed_w, "R7 write packing", dreg, packed_w);
        for (int k = 0; k < sz; k++) mem[e_addr + k] = dreg[8*k +: 8];
      end else begin
        dreg = 32'hEEEE_EEEE;
        for (int k = 0; k < sz; k++) dreg[8*k +: 8] = mem[e_addr + k];
      end
      loaded       = 1'b0;
      polled_clear = 1'b0;
      lastcmd      = reg_wdata;
      pend         = pcfg;
      e_addr += sz; e_off += sz; e_rem -= sz;
      chunks++;
    end else if (!reg_we && reg_addr == 16'h0304) begin
      polls++;
      if (pend > 0) begin
        reg_rdata = lastcmd | 32'h8000_0000;
        pend--;
      end else begin
        reg_rdata    = lastcmd & 32'h7FFF_FFFF;
        polled_clear = 1'b1;
      end
    end else if (!reg_we && reg_addr == 16'h0300) begin
      chk(polled_clear, "R5 data read after clear", 0, 1);
      reg_rdata = dreg;
    end else begin
      chk(1'b0, "R2 register address", reg_addr, 16'h0304);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (active) begin
        if (done || err) begin
          active = 1'b0;
          if (busy) gaps++;
        end else if (!busy) gaps++;
      end
      if (buf_we)
        for (int k = 0; k < 4; k++)
          if (k < int'(buf_wsize) && int'(buf_wptr) + k < 16)
            lbuf[int'(buf_wptr) + k] = buf_wdata[8*k +: 8];
      if (reg_ack) begin
        reg_ack = 1'b0;
        lat_cnt = 0;
      end else if (reg_req) begin
        if (lat_cnt > 0) chk(reg_addr == hold_a && reg_we == hold_we, "R1 request held", reg_addr, hold_a);
        hold_a  = reg_addr;
        hold_we = reg_we;
        if (lat_cnt < lat_cfg) lat_cnt++;
        else begin
          service();
          reg_ack = 1'b1;
        end
      end
    end
  end

  task automatic run_req(input bit wr, input int a, input int n, input int pc,
                         input int lat, input bit poke, input bit exp_err);
    int exp_chunks, ea, er, s;
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 13 + 5) & 255);
    for (int i = 0; i < 16; i++) lbuf[i] = wr ? 8'(8'h90 + i * 3) : 8'h5A;
    e_addr = a; e_rem = n; e_off = 0; e_rd = !wr;
    chunks = 0; polls = 0; xfers = 0; done_cnt = 0; err_cnt = 0; gaps = 0;
    loaded = 0; polled_clear = 0; pcfg = pc; lat_cfg = lat; lat_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(a); req_len = LEN_W'(n);
    @(negedge clk);
    req_valid = 1'b0; active = 1'b1;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_addr = 16'h0200; req_len = 3;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int w = 0; w < 600 && done_cnt == 0 && err_cnt == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(gaps == 0, "R9 busy held until end", gaps, 0);
    if (exp_err) begin
      chk(err_cnt == 1, "R10 timeout error pulse", err_cnt, 1);
      chk(done_cnt == 0, "R10 no done on timeout", done_cnt, 0);
      chk(polls == LIMIT, "R10 polls before timeout", polls, LIMIT);
      return;
    end
    exp_chunks = 0; ea = a; er = n;
    while (er > 0) begin
      s = exp_size(ea, er);
      ea += s; er -= s; exp_chunks++;
    end
    chk(done_cnt == 1, poke ? "R11 single done with stray start" : "R9 done pulse", done_cnt, 1);
    chk(err_cnt == 0, "R10 no error", err_cnt, 0);
    chk(chunks == exp_chunks, poke ? "R11 no extra commands" : "R3 R6 chunk count", chunks, exp_chunks);
    chk(polls == exp_chunks * (pc + 1), "R4 poll count", polls, exp_chunks * (pc + 1));
    if (n == 0) chk(xfers == 0, "R9 zero length has no traffic", xfers, 0);
    if (wr) begin
      for (int i = 0; i < n; i++)
        chk(mem[a + i] == lbuf[i], "R6 R7 byte written", mem[a + i], lbuf[i]);
      chk(mem[a + n] == 8'(((a + n) * 13 + 5) & 255), "R6 byte after untouched", mem[a + n], ((a + n) * 13 + 5) & 255);
      chk(mem[a - 1] == 8'(((a - 1) * 13 + 5) & 255), "R6 byte before untouched", mem[a - 1], ((a - 1) * 13 + 5) & 255);
    end else begin
      for (int i = 0; i < n; i++)
        chk(lbuf[i] == mem[a + i], "R6 R8 byte read", lbuf[i], mem[a + i]);
      chk(lbuf[n] == 8'h5A, "R8 buffer beyond request untouched", lbuf[n], 8'h5A);
    end
  endtask

  initial begin
    active = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R9 reset idle", {busy, done, err}, 0);
    chk(!reg_req && !buf_we, "R1 reset no traffic", {reg_req, buf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int wr = 0; wr < 2; wr++)
      for (int off = 0; off < 4; off++)
        for (int n = 0; n < 10; n++)
          run_req(wr[0], 16'h0130 + off, n, (off + n) % 3, n % 3, 1'b0, 1'b0);
    // busy clears on the last allowed poll: success (R10)
    run_req(1'b0, 16'h0142, 2, LIMIT - 1, 0, 1'b0, 1'b0);
    run_req(1'b1, 16'h0148, 4, LIMIT - 1, 1, 1'b0, 1'b0);
    // one more busy answer: timeout (R10)
    run_req(1'b1, 16'h0141, 1, LIMIT, 0, 1'b0, 1'b1);
    run_req(1'b0, 16'h0144, 6, LIMIT, 1, 1'b0, 1'b1);
    // start pulse while busy is ignored (R11)
    run_req(1'b0, 16'h0151, 7, 1, 1, 1'b1, 1'b0);
    run_req(1'b1, 16'h0160, 9, 2, 0, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule